// File: doc/BRIEF.md
# Pinned LRU Fence Slot Allocator

This block hands out a small pool of fence slots (8, 16 or 32, chosen by the `NUM_SLOTS` parameter) to requesters that want a slot bound to an object ID. Each slot keeps a binding (valid flag and object ID), a pin count and a position in a least-recently-used order. Requesters issue one command per cycle. The command can pin an object, unpin a slot, revoke an object's slot, reserve a slot out of the pool, or return a reserved slot to the pool. The result comes back one cycle later as a slot index or an error code.

Writing the detiling hardware itself is done elsewhere. When a binding is created or torn down, this block emits a one-cycle programming strobe that carries the slot, the object and whether the slot is being bound or cleared. A separate programmer acts on that strobe. The LRU order is held as one rank value per slot. Rank 0 is the least-recently-used end and rank `NUM_SLOTS-1` is the most-recently-used end. Every move in the order is a single-cycle rank update.

Top module: `fslot_alloc`

## Requirements
- R1: After reset every slot is unbound, unpinned and in the pool, and the LRU order is slot 0 (least recent) up to slot NUM_SLOTS-1 (most recent). A command accepted at one clock edge has its result on `rsp_*` after that edge, with `rsp_valid` high for exactly that cycle. `rsp_err` uses these codes: 0 ok, 1 retry, 2 deadlock, 3 busy, 4 no-space, 5 underflow, 6 saturated. `cmd_op` uses these codes: 0 pin, 1 unpin, 2 revoke, 3 reserve, 4 unreserve.
- R2: A pin (op 0) for an object already bound to a slot increments that slot's pin count and moves it to the most-recent end. It returns that slot with code 0 and produces no programming strobe.
- R3: A pin of an object that holds no slot and has `cmd_tiled` low returns code 0 with `rsp_has_slot` low. No slot changes.
- R4: A pin of a tiled object that holds no slot takes as victim the first in-pool slot with pin count zero, searching from the least-recent end. The victim's old binding is dropped and the new object is bound with pin count 1. The victim moves to the most-recent end, and a strobe with `prog_bind`=1, the slot and the object is emitted.
- R5: When a tiled pin finds no victim, the result is code 1 (retry) if `flip_pending` is high and code 2 (deadlock) if it is low. No state changes.
- R6: A revoke (op 2) of an unbound object returns code 0 with no slot. If the object's slot has a non-zero pin count, the result is code 3 (busy). Otherwise the slot is unbound, moved to the least-recent end, returned, and a strobe with `prog_bind`=0 is emitted.
- R7: A reserve (op 3) returns code 4 unless at least two in-pool slots are unpinned. Otherwise it takes the slot that R4's search would pick, removes it from the pool and returns it. If that slot was bound, the reserve also unbinds it and emits a clear strobe.
- R8: An unreserve (op 4) of slot `cmd_slot` puts it back in the pool at the least-recent end.
- R9: An unpin (op 1) of `cmd_slot` decrements its pin count. If the count is already zero, the result is code 5 and the count stays zero.
- R10: A pin that hits a slot whose pin count is at its maximum (2^PIN_W-1) returns code 6 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (R1) |
| cmd_obj | input | OBJ_W | Object ID for pin and revoke |
| cmd_tiled | input | 1 | Object needs a slot (pin) |
| cmd_slot | input | $clog2(NUM_SLOTS) | Slot for unpin and unreserve |
| flip_pending | input | 1 | Selects retry instead of deadlock |
| rsp_valid | output | 1 | Result present |
| rsp_err | output | 3 | Result code |
| rsp_has_slot | output | 1 | rsp_slot is meaningful |
| rsp_slot | output | $clog2(NUM_SLOTS) | Returned slot |
| prog_valid | output | 1 | Programming strobe |
| prog_bind | output | 1 | 1 bind, 0 clear |
| prog_slot | output | $clog2(NUM_SLOTS) | Slot to program |
| prog_obj | output | OBJ_W | Object to bind |

## Verification
Two things can happen in the same cycle. A tiled pin that misses tears down the victim's previous binding and creates the new one in a single edge. A reserve of a bound slot clears its binding and removes it from the pool at once. The bench sets up both cases with directed steps and then with many random commands over a small ID set, so steals of live bindings occur often. It checks the outcome with later commands: a pin of the evicted object must now miss, and the reserved slot must never be chosen until it is returned. A reference model in the bench predicts every result code, slot and strobe.

// File: rtl/fslot_pkg.sv
package fslot_pkg;

    typedef enum logic [2:0] {
        OP_PIN       = 3'd0,
        OP_UNPIN     = 3'd1,
        OP_REVOKE    = 3'd2,
        OP_RESERVE   = 3'd3,
        OP_UNRESERVE = 3'd4
    } fslot_op_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_RETRY     = 3'd1,
        ERR_DEADLOCK  = 3'd2,
        ERR_BUSY      = 3'd3,
        ERR_NOSPACE   = 3'd4,
        ERR_UNDERFLOW = 3'd5,
        ERR_SATURATED = 3'd6
    } fslot_err_e;

    function automatic bit fslot_count_ok(int n);
        return (n == 8) || (n == 16) || (n == 32);
    endfunction

endpackage

// File: rtl/fslot_match.sv
module fslot_match #(
    parameter int NUM_SLOTS = 8,
    parameter int OBJ_W     = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0]            bound,
    input  logic [NUM_SLOTS-1:0][OBJ_W-1:0] obj_tab,
    input  logic [OBJ_W-1:0]                key,
    output logic                            hit,
    output logic [IDX_W-1:0]                hit_idx
);
    logic [NUM_SLOTS-1:0] hv;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
        assign hv[i] = bound[i] && (obj_tab[i] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (hv[i]) hit_idx = IDX_W'(i);
    end

    assign hit = |hv;
endmodule

// File: rtl/fslot_victim.sv
module fslot_victim #(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0]            elig,
    input  logic [NUM_SLOTS-1:0][IDX_W-1:0] rank,
    output logic                            found,
    output logic [IDX_W-1:0]                idx,
    output logic [IDX_W:0]                  count
);
    logic [NUM_SLOTS-1:0] win;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_win
        always_comb begin
            win[i] = elig[i];
            for (int j = 0; j < NUM_SLOTS; j++)
                if (j != i && elig[j] && rank[j] < rank[i]) win[i] = 1'b0;
        end
    end

    always_comb begin
        idx   = '0;
        count = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (win[i]) idx = IDX_W'(i);
            count = count + (IDX_W+1)'(elig[i]);
        end
    end

    assign found = |elig;
endmodule

// File: rtl/fslot_rank.sv
module fslot_rank #(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            mv_en,
    input  logic [IDX_W-1:0]                mv_slot,
    input  logic                            mv_mru,
    output logic [NUM_SLOTS-1:0][IDX_W-1:0] rank
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_SLOTS - 1);
    logic [IDX_W-1:0] pivot;

    assign pivot = rank[mv_slot];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_rank
        always_ff @(posedge clk) begin
            if (rst) begin
                rank[i] <= IDX_W'(i);
            end else if (mv_en) begin
                if (mv_slot == IDX_W'(i))
                    rank[i] <= mv_mru ? TOP : '0;
                else if (mv_mru && rank[i] > pivot)
                    rank[i] <= rank[i] - 1'b1;
                else if (!mv_mru && rank[i] < pivot)
                    rank[i] <= rank[i] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fslot_alloc.sv
module fslot_alloc
    import fslot_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int OBJ_W     = 16,
    parameter int PIN_W     = 4,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [OBJ_W-1:0] cmd_obj,
    input  logic             cmd_tiled,
    input  logic [IDX_W-1:0] cmd_slot,
    input  logic             flip_pending,
    output logic             rsp_valid,
    output logic [2:0]       rsp_err,
    output logic             rsp_has_slot,
    output logic [IDX_W-1:0] rsp_slot,
    output logic             prog_valid,
    output logic             prog_bind,
    output logic [IDX_W-1:0] prog_slot,
    output logic [OBJ_W-1:0] prog_obj
);
    localparam logic [PIN_W-1:0] PIN_MAX = {PIN_W{1'b1}};

    initial begin
        if (!fslot_count_ok(NUM_SLOTS))
            $error("fslot_alloc: NUM_SLOTS must be 8, 16 or 32");
    end

    logic [NUM_SLOTS-1:0]             bound_q, resv_q;
    logic [NUM_SLOTS-1:0][OBJ_W-1:0]  obj_q;
    logic [NUM_SLOTS-1:0][PIN_W-1:0]  pin_q;
    logic [NUM_SLOTS-1:0][IDX_W-1:0]  rank;
    logic [NUM_SLOTS-1:0]             elig;

    logic             hit, vic_found;
    logic [IDX_W-1:0] hit_idx, vic_idx;
    logic [IDX_W:0]   free_cnt;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_elig
        assign elig[i] = !resv_q[i] && (pin_q[i] == '0);
    end

    fslot_match #(.NUM_SLOTS(NUM_SLOTS), .OBJ_W(OBJ_W)) u_match (
        .bound(bound_q), .obj_tab(obj_q), .key(cmd_obj),
        .hit(hit), .hit_idx(hit_idx)
    );

    fslot_victim #(.NUM_SLOTS(NUM_SLOTS)) u_victim (
        .elig(elig), .rank(rank),
        .found(vic_found), .idx(vic_idx), .count(free_cnt)
    );

    // decision for the current command
    fslot_err_e       nx_err;
    logic             nx_has, do_move, mv_mru, do_inc, do_dec;
    logic             do_bind, do_unbind, do_resv, do_unresv, do_prog;
    logic [IDX_W-1:0] tgt;

    always_comb begin
        nx_err    = ERR_NONE;
        nx_has    = 1'b0;
        tgt       = cmd_slot;
        do_move   = 1'b0;
        mv_mru    = 1'b0;
        do_inc    = 1'b0;
        do_dec    = 1'b0;
        do_bind   = 1'b0;
        do_unbind = 1'b0;
        do_resv   = 1'b0;
        do_unresv = 1'b0;
        do_prog   = 1'b0;
        case (fslot_op_e'(cmd_op))
            OP_PIN: begin
                if (hit) begin
                    tgt = hit_idx;
                    if (pin_q[hit_idx] == PIN_MAX) begin
                        nx_err = ERR_SATURATED;
                    end else begin
                        nx_has  = 1'b1;
                        do_inc  = 1'b1;
                        do_move = 1'b1;
                        mv_mru  = 1'b1;
                    end
                end else if (cmd_tiled) begin
                    if (vic_found) begin
                        tgt     = vic_idx;
                        nx_has  = 1'b1;
                        do_inc  = 1'b1;
                        do_bind = 1'b1;
                        do_prog = 1'b1;
                        do_move = 1'b1;
                        mv_mru  = 1'b1;
                    end else begin
                        nx_err = flip_pending ? ERR_RETRY : ERR_DEADLOCK;
                    end
                end
            end
            OP_UNPIN: begin
                if (pin_q[cmd_slot] == '0) nx_err = ERR_UNDERFLOW;
                else                       do_dec = 1'b1;
            end
            OP_REVOKE: begin
                if (hit) begin
                    tgt = hit_idx;
                    if (pin_q[hit_idx] != '0) begin
                        nx_err = ERR_BUSY;
                    end else begin
                        nx_has    = 1'b1;
                        do_unbind = 1'b1;
                        do_prog   = 1'b1;
                        do_move   = 1'b1;
                    end
                end
            end
            OP_RESERVE: begin
                if (free_cnt < (IDX_W+1)'(2)) begin
                    nx_err = ERR_NOSPACE;
                end else begin
                    tgt       = vic_idx;
                    nx_has    = 1'b1;
                    do_resv   = 1'b1;
                    do_unbind = 1'b1;
                    do_prog   = bound_q[vic_idx];
                end
            end
            OP_UNRESERVE: begin
                do_unresv = 1'b1;
                do_move   = 1'b1;
            end
            default: ;
        endcase
    end

    fslot_rank #(.NUM_SLOTS(NUM_SLOTS)) u_rank (
        .clk(clk), .rst(rst),
        .mv_en(cmd_valid && do_move), .mv_slot(tgt), .mv_mru(mv_mru),
        .rank(rank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_q      <= '0;
            resv_q       <= '0;
            obj_q        <= '0;
            pin_q        <= '0;
            rsp_valid    <= 1'b0;
            rsp_err      <= ERR_NONE;
            rsp_has_slot <= 1'b0;
            rsp_slot     <= '0;
            prog_valid   <= 1'b0;
            prog_bind    <= 1'b0;
            prog_slot    <= '0;
            prog_obj     <= '0;
        end else begin
            rsp_valid    <= cmd_valid;
            rsp_err      <= cmd_valid ? nx_err : ERR_NONE;
            rsp_has_slot <= cmd_valid && nx_has;
            rsp_slot     <= tgt;
            prog_valid   <= cmd_valid && do_prog;
            prog_bind    <= do_bind;
            prog_slot    <= tgt;
            prog_obj     <= cmd_obj;
            if (cmd_valid) begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (tgt == IDX_W'(i)) begin
                        if (do_bind)   begin bound_q[i] <= 1'b1; obj_q[i] <= cmd_obj; end
                        if (do_unbind) bound_q[i] <= 1'b0;
                        if (do_inc)    pin_q[i] <= pin_q[i] + 1'b1;
                        if (do_dec)    pin_q[i] <= pin_q[i] - 1'b1;
                        if (do_resv)   resv_q[i] <= 1'b1;
                        if (do_unresv) resv_q[i] <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fslot_alloc_chk.sv
module fslot_alloc_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int OBJ_W     = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             flip_pending,
    input logic             rsp_valid,
    input logic [2:0]       rsp_err,
    input logic             rsp_has_slot,
    input logic             prog_valid,
    input logic             prog_bind
);
    assert_rsp_after_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);

    assert_rsp_needs_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd_valid));

    assert_retry_on_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err == 3'd1) |-> $past(flip_pending));

    assert_deadlock_no_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err == 3'd2) |-> !$past(flip_pending));

    assert_strobe_with_ok_R4: assert property (@(posedge clk) disable iff (rst)
        prog_valid |-> (rsp_valid && rsp_err == 3'd0 && rsp_has_slot));

    assert_bind_only_pin_R4: assert property (@(posedge clk) disable iff (rst)
        (prog_valid && prog_bind) |-> ($past(cmd_op) == 3'd0));

    assert_nospace_only_reserve_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err == 3'd4) |-> ($past(cmd_op) == 3'd3));

    assert_underflow_only_unpin_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err == 3'd5) |-> ($past(cmd_op) == 3'd1));
endmodule

bind fslot_alloc fslot_alloc_chk #(.NUM_SLOTS(NUM_SLOTS), .OBJ_W(OBJ_W)) u_chk (.*);

// File: tb/fslot_alloc_test.sv
module fslot_alloc_test;
    localparam int NS    = 8;
    localparam int OW    = 16;
    localparam int PW    = 4;
    localparam int IW    = $clog2(NS);
    localparam int PMAX  = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [OW-1:0] cmd_obj = '0;
    logic          cmd_tiled = 1'b0;
    logic [IW-1:0] cmd_slot = '0;
    logic          flip_pending = 1'b0;
    logic          rsp_valid, rsp_has_slot, prog_valid, prog_bind;
    logic [2:0]    rsp_err;
    logic [IW-1:0] rsp_slot, prog_slot;
    logic [OW-1:0] prog_obj;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fslot_alloc #(.NUM_SLOTS(NS), .OBJ_W(OW), .PIN_W(PW)) uut (.*);

    // reference model
    int m_rank [NS];
    bit m_bound[NS];
    bit m_resv [NS];
    int m_obj  [NS];
    int m_pin  [NS];

    function automatic void m_reset();
        for (int i = 0; i < NS; i++) begin
            m_rank[i] = i; m_bound[i] = 0; m_resv[i] = 0; m_obj[i] = 0; m_pin[i] = 0;
        end
    endfunction

    function automatic void m_move(int s, bit mru);
        int p = m_rank[s];
        for (int i = 0; i < NS; i++) begin
            if (i == s) continue;
            if (mru && m_rank[i] > p) m_rank[i]--;
            if (!mru && m_rank[i] < p) m_rank[i]++;
        end
        m_rank[s] = mru ? NS - 1 : 0;
    endfunction

    function automatic int m_victim();
        for (int r = 0; r < NS; r++)
            for (int s = 0; s < NS; s++)
                if (m_rank[s] == r && !m_resv[s] && m_pin[s] == 0) return s;
        return -1;
    endfunction

    function automatic int m_lookup(int o);
        for (int s = 0; s < NS; s++)
            if (m_bound[s] && m_obj[s] == o) return s;
        return -1;
    endfunction

    function automatic int m_free();
        int c = 0;
        for (int s = 0; s < NS; s++) if (!m_resv[s] && m_pin[s] == 0) c++;
        return c;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic issue(string tag, int op, int obj, bit tiled, int slot, bit flip);
        int e_err = 0, e_slot = 0, e_pobj = 0, h, v;
        bit e_has = 0, e_pv = 0, e_pb = 0;
        case (op)
            0: begin
                h = m_lookup(obj);
                if (h >= 0) begin
                    if (m_pin[h] == PMAX) e_err = 6;
                    else begin m_pin[h]++; m_move(h, 1); e_has = 1; e_slot = h; end
                end else if (tiled) begin
                    v = m_victim();
                    if (v < 0) e_err = flip ? 1 : 2;
                    else begin
                        m_bound[v] = 1; m_obj[v] = obj; m_pin[v] = 1; m_move(v, 1);
                        e_has = 1; e_slot = v; e_pv = 1; e_pb = 1; e_pobj = obj;
                    end
                end
            end
            1: begin
                if (m_pin[slot] == 0) e_err = 5; else m_pin[slot]--;
            end
            2: begin
                h = m_lookup(obj);
                if (h >= 0) begin
                    if (m_pin[h] != 0) e_err = 3;
                    else begin m_bound[h] = 0; m_move(h, 0); e_has = 1; e_slot = h; e_pv = 1; end
                end
            end
            3: begin
                if (m_free() < 2) e_err = 4;
                else begin
                    v = m_victim();
                    e_has = 1; e_slot = v; e_pv = m_bound[v];
                    m_resv[v] = 1; m_bound[v] = 0;
                end
            end
            default: begin
                m_resv[slot] = 0; m_move(slot, 0);
            end
        endcase
        cmd_valid = 1; cmd_op = 3'(op); cmd_obj = OW'(obj);
        cmd_tiled = tiled; cmd_slot = IW'(slot); flip_pending = flip;
        @(posedge clk);
        #2;
        check(tag, "rsp_valid", int'(rsp_valid), 1);
        check(tag, "rsp_err", int'(rsp_err), e_err);
        check(tag, "rsp_has_slot", int'(rsp_has_slot), int'(e_has));
        if (e_has) check(tag, "rsp_slot", int'(rsp_slot), e_slot);
        check(tag, "prog_valid", int'(prog_valid), int'(e_pv));
        if (e_pv) begin
            check(tag, "prog_bind", int'(prog_bind), int'(e_pb));
            check(tag, "prog_slot", int'(prog_slot), e_slot);
            if (e_pb) check(tag, "prog_obj", int'(prog_obj), e_pobj);
        end
        @(negedge clk);
        cmd_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_1234;
        int r, op, s;
        void'($urandom(seed));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1", "rsp_valid idle", int'(rsp_valid), 0);
        check("R1", "prog_valid idle", int'(prog_valid), 0);

        for (int i = 0; i < NS; i++) issue("R4", 0, 100 + i, 1, 0, 0); // R1 order: slots 0..7
        issue("R2", 0, 100, 1, 0, 0);
        issue("R3", 0, 200, 0, 0, 0);
        issue("R5", 0, 201, 1, 0, 0);
        issue("R5", 0, 201, 1, 0, 1);
        issue("R6", 2, 100, 0, 0, 0);
        issue("R9", 1, 0, 0, 0, 0);
        issue("R9", 1, 0, 0, 0, 0);
        issue("R9", 1, 0, 0, 0, 0);
        issue("R6", 2, 100, 0, 0, 0);
        issue("R6", 2, 100, 0, 0, 0);
        issue("R7", 3, 0, 0, 0, 0);
        issue("R9", 1, 0, 0, 1, 0);
        issue("R7", 3, 0, 0, 0, 0);
        issue("R4", 0, 201, 1, 0, 0);
        issue("R4", 0, 101, 0, 0, 0);
        issue("R5", 0, 101, 1, 0, 0);
        issue("R8", 4, 0, 0, 0, 0);
        issue("R8", 0, 300, 1, 0, 0);
        for (int i = 0; i < PMAX; i++) issue("R10", 0, 201, 1, 0, 0);

        for (int k = 0; k < 4000; k++) begin
            r = int'($urandom_range(99));
            s = int'($urandom_range(NS - 1));
            if (r < 40) op = 0;
            else if (r < 70) op = 1;
            else if (r < 80) op = 2;
            else if (r < 88) op = 3;
            else op = 4;
            if (op == 1 && $urandom_range(9) < 7)
                for (int j = 0; j < NS; j++)
                    if (m_pin[(s + j) % NS] > 0) begin s = (s + j) % NS; break; end
            case (op)
                0: issue("R2 R3 R4 R5 R10", 0, int'($urandom_range(11)), 1'($urandom_range(1)), 0, 1'($urandom_range(1)));
                1: issue("R9", 1, 0, 0, s, 0);
                2: issue("R6", 2, int'($urandom_range(11)), 0, 0, 0);
                3: issue("R7", 3, 0, 0, 0, 0);
                default: issue("R8", 4, 0, 0, s, 0);
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule